// File: doc/BRIEF.md
# Interrupt-Driven Register Page Stack

This block keeps the page selector that an 8-bit microcontroller core uses to decode its special-function-register addresses. The same register address can reach different registers depending on the page. For example, one address on page 0x0F reaches an I/O port register. Behind the live page register sit two saved entries, so the block holds a three-deep stack of page values.

When the core accepts an interrupt and automatic paging is enabled, the block saves the live page one level down. It then loads the page that belongs to the interrupting source, taken from a per-source parameter table. Each service routine therefore starts already pointed at its own peripheral's registers. A return from interrupt pops the stack, so a preempted routine, or the main code, gets its page back. This also works when a high-priority interrupt has nested inside a low-priority one.

Software can read all three entries at any time and can overwrite any of them. This lets a routine switch to another page in the middle of its work.

Top module: `reg_page_stack`

## Requirements
- R1: After reset, the live, next and last entries all read 0x00 and `autoEnable` reads 1.
- R2: When `intAccept` is high and `autoEnable` is 1, the following happens on the next clock edge:
  - next takes the old live value;
  - last takes the old next value, and the old last value is lost;
  - live takes the table entry for `intSrc`.
  - The default table, by index 0..7, is 0x00, 0x02, 0x01, 0x0F, 0x03, 0x00, 0x0A, 0x05. Index 1 is the ADC window-compare source, on page 0x02.
- R3: Two or three back-to-back accepts, as with nested priorities, each push exactly one level. After three pushes the page saved first is gone.
- R4: When `intReturn` is high, `intAccept` is low and `autoEnable` is 1, the following happens on the next edge: live takes next, next takes last, and last keeps its value.
- R5: While `autoEnable` is 0, `intAccept` and `intReturn` leave all three entries unchanged.
- R6: A write strobe (`wrTopEn`, `wrNextEn` or `wrLastEn`) loads `wrData` into its entry on the next edge. This works whatever the state of `autoEnable` and at any point inside a service routine.
- R7: A push or pop in the same cycle as any software entry write wins. The write is dropped.
- R8: When `intAccept` and `intReturn` are both high with `autoEnable` at 1, the push is performed and the return is ignored.
- R9: `enWr` loads `enData` into `autoEnable` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intAccept | input | 1 | Interrupt-accept strobe from the core |
| intSrc | input | SRC_W | Index of the accepted source |
| intReturn | input | 1 | Return-from-interrupt strobe |
| wrTopEn | input | 1 | Software write to the live entry |
| wrNextEn | input | 1 | Software write to the next entry |
| wrLastEn | input | 1 | Software write to the last entry |
| wrData | input | 8 | Data for the software entry writes |
| enWr | input | 1 | Write strobe for the enable bit |
| enData | input | 1 | New enable value |
| curPage | output | 8 | Live page used for address decode |
| nextPage | output | 8 | Read-back of the next entry |
| lastPage | output | 8 | Read-back of the last entry |
| autoEnable | output | 1 | Read-back of the enable bit |

## Verification
The properties take `intSrc` as meaningful only in a cycle where `intAccept` is high. They also assume that the strobes are single-cycle pulses sampled on the rising edge, with no ordering assumed among them. The stimulus drives every input at the falling edge and keeps each strobe to one cycle. It deliberately overlaps strobes in the cycles that exercise priority: a push with a live write, an accept with a return, and a pop with a next write. It also runs a nested sequence deeper than the stack, so that the discarded bottom entry is observed.

// File: rtl/pgstk_pkg.sv
package pgstk_pkg;
  localparam int PAGE_W = 8;
  typedef logic [PAGE_W-1:0] page_t;

  typedef struct packed {
    logic  push;
    logic  pop;
    logic  wrTop;
    logic  wrNext;
    logic  wrLast;
    page_t loadPage;
    page_t wrData;
  } stackCmd_t;
endpackage

// File: rtl/page_lookup.sv
module page_lookup
  import pgstk_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W = 3,
  parameter logic [NUM_SRC*PAGE_W-1:0] PAGE_MAP = '0
) (
  input  logic [SRC_W-1:0] srcIdx,
  output page_t            srcPage
);
  localparam int SLOTS = 2 ** SRC_W;

  page_t table_q [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NUM_SRC) begin : g_used
      assign table_q[i] = PAGE_MAP[i*PAGE_W +: PAGE_W];
    end else begin : g_pad
      assign table_q[i] = '0;
    end
  end

  assign srcPage = table_q[srcIdx];
endmodule

// File: rtl/page_stack_ctrl.sv
module page_stack_ctrl
  import pgstk_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W = 3,
  parameter logic [NUM_SRC*PAGE_W-1:0] PAGE_MAP = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intAccept,
  input  logic [SRC_W-1:0] intSrc,
  input  logic             intReturn,
  input  logic             wrTopEn,
  input  logic             wrNextEn,
  input  logic             wrLastEn,
  input  page_t            wrData,
  input  logic             enWr,
  input  logic             enData,
  output logic             autoEn,
  output stackCmd_t        cmd
);
  page_t srcPage;
  logic  hwMove;

  page_lookup #(
    .NUM_SRC (NUM_SRC),
    .SRC_W   (SRC_W),
    .PAGE_MAP(PAGE_MAP)
  ) lookupI (
    .srcIdx (intSrc),
    .srcPage(srcPage)
  );

  always_ff @(posedge clk) begin
    if (!rstN) autoEn <= 1'b1;
    else if (enWr) autoEn <= enData;
  end

  always_comb begin
    cmd.push     = autoEn & intAccept;
    cmd.pop      = autoEn & intReturn & ~intAccept;
    hwMove       = cmd.push | cmd.pop;
    cmd.wrTop    = wrTopEn & ~hwMove;
    cmd.wrNext   = wrNextEn & ~hwMove;
    cmd.wrLast   = wrLastEn & ~hwMove;
    cmd.loadPage = srcPage;
    cmd.wrData   = wrData;
  end
endmodule

// File: rtl/page_stack_dp.sv
module page_stack_dp
  import pgstk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  stackCmd_t cmd,
  output page_t     topQ,
  output page_t     nextQ,
  output page_t     lastQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      topQ  <= '0;
      nextQ <= '0;
      lastQ <= '0;
    end else if (cmd.push) begin
      topQ  <= cmd.loadPage;
      nextQ <= topQ;
      lastQ <= nextQ;
    end else if (cmd.pop) begin
      topQ  <= nextQ;
      nextQ <= lastQ;
    end else begin
      if (cmd.wrTop)  topQ  <= cmd.wrData;
      if (cmd.wrNext) nextQ <= cmd.wrData;
      if (cmd.wrLast) lastQ <= cmd.wrData;
    end
  end
endmodule

// File: rtl/reg_page_stack.sv
module reg_page_stack
  import pgstk_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W = $clog2(NUM_SRC),
  parameter logic [NUM_SRC*PAGE_W-1:0] PAGE_MAP = 64'h05_0A_00_03_0F_01_02_00
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intAccept,
  input  logic [SRC_W-1:0] intSrc,
  input  logic             intReturn,
  input  logic             wrTopEn,
  input  logic             wrNextEn,
  input  logic             wrLastEn,
  input  logic [7:0]       wrData,
  input  logic             enWr,
  input  logic             enData,
  output logic [7:0]       curPage,
  output logic [7:0]       nextPage,
  output logic [7:0]       lastPage,
  output logic             autoEnable
);
  stackCmd_t cmd;

  page_stack_ctrl #(
    .NUM_SRC (NUM_SRC),
    .SRC_W   (SRC_W),
    .PAGE_MAP(PAGE_MAP)
  ) ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .intAccept(intAccept),
    .intSrc   (intSrc),
    .intReturn(intReturn),
    .wrTopEn  (wrTopEn),
    .wrNextEn (wrNextEn),
    .wrLastEn (wrLastEn),
    .wrData   (wrData),
    .enWr     (enWr),
    .enData   (enData),
    .autoEn   (autoEnable),
    .cmd      (cmd)
  );

  page_stack_dp dpI (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (cmd),
    .topQ (curPage),
    .nextQ(nextPage),
    .lastQ(lastPage)
  );
endmodule

// File: rtl/page_stack_chk.sv
module page_stack_chk
  import pgstk_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W = 3,
  parameter logic [NUM_SRC*PAGE_W-1:0] PAGE_MAP = '0
) (
  input logic             clk,
  input logic             rstN,
  input logic             intAccept,
  input logic [SRC_W-1:0] intSrc,
  input logic             intReturn,
  input logic             wrTopEn,
  input logic             wrNextEn,
  input logic             wrLastEn,
  input logic [7:0]       wrData,
  input logic             enWr,
  input logic             enData,
  input logic [7:0]       curPage,
  input logic [7:0]       nextPage,
  input logic [7:0]       lastPage,
  input logic             autoEnable
);
  logic [7:0] expSrcPage;
  logic       anyWr;

  always_comb begin
    expSrcPage = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (int'(intSrc) == i) expSrcPage = PAGE_MAP[i*PAGE_W +: PAGE_W];
    anyWr = wrTopEn | wrNextEn | wrLastEn;
  end

  // R2
  push_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    autoEnable && intAccept |=> curPage == $past(expSrcPage)
      && nextPage == $past(curPage) && lastPage == $past(nextPage));

  // R4
  pop_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    autoEnable && intReturn && !intAccept |=> curPage == $past(nextPage)
      && nextPage == $past(lastPage) && $stable(lastPage));

  // R5
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !autoEnable && !enWr && (intAccept || intReturn) && !anyWr |=>
      $stable(curPage) && $stable(nextPage) && $stable(lastPage));

  // R6
  sw_top_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrTopEn && !(autoEnable && (intAccept || intReturn)) |=> curPage == $past(wrData));

  // R9
  enable_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    enWr |=> autoEnable == $past(enData));
endmodule

bind reg_page_stack page_stack_chk #(
  .NUM_SRC (NUM_SRC),
  .SRC_W   (SRC_W),
  .PAGE_MAP(PAGE_MAP)
) chkI (
  .clk       (clk),
  .rstN      (rstN),
  .intAccept (intAccept),
  .intSrc    (intSrc),
  .intReturn (intReturn),
  .wrTopEn   (wrTopEn),
  .wrNextEn  (wrNextEn),
  .wrLastEn  (wrLastEn),
  .wrData    (wrData),
  .enWr      (enWr),
  .enData    (enData),
  .curPage   (curPage),
  .nextPage  (nextPage),
  .lastPage  (lastPage),
  .autoEnable(autoEnable)
);

// File: tb/tb_reg_page_stack.sv
module tb_reg_page_stack;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       intAccept = 1'b0;
  logic [2:0] intSrc = '0;
  logic       intReturn = 1'b0;
  logic       wrTopEn = 1'b0;
  logic       wrNextEn = 1'b0;
  logic       wrLastEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       enWr = 1'b0;
  logic       enData = 1'b0;
  logic [7:0] curPage, nextPage, lastPage;
  logic       autoEnable;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_page_stack dut (
    .clk(clk), .rstN(rstN), .intAccept(intAccept), .intSrc(intSrc),
    .intReturn(intReturn), .wrTopEn(wrTopEn), .wrNextEn(wrNextEn),
    .wrLastEn(wrLastEn), .wrData(wrData), .enWr(enWr), .enData(enData),
    .curPage(curPage), .nextPage(nextPage), .lastPage(lastPage),
    .autoEnable(autoEnable)
  );

  typedef struct {
    logic [7:0] top;
    logic [7:0] nxt;
    logic [7:0] lst;
    logic       en;
    string      tag;
  } expItem_t;

  expItem_t   sbQ[$];
  int         nCmp = 0;
  int         nBad = 0;
  logic       done = 1'b0;
  logic [7:0] mTop = 8'h00, mNext = 8'h00, mLast = 8'h00;
  logic       mEn = 1'b1;

  // source page table as given in R2
  function automatic logic [7:0] pageOf(input logic [2:0] s);
    case (s)
      3'd0: return 8'h00;
      3'd1: return 8'h02;
      3'd2: return 8'h01;
      3'd3: return 8'h0F;
      3'd4: return 8'h03;
      3'd5: return 8'h00;
      3'd6: return 8'h0A;
      default: return 8'h05;
    endcase
  endfunction

  task automatic compare(input expItem_t e);
    nCmp++;
    if (curPage !== e.top || nextPage !== e.nxt || lastPage !== e.lst || autoEnable !== e.en) begin
      nBad++;
      $display("FAIL %s: got top=%h next=%h last=%h en=%b, expected top=%h next=%h last=%h en=%b",
               e.tag, curPage, nextPage, lastPage, autoEnable, e.top, e.nxt, e.lst, e.en);
    end
  endtask

  task automatic step(input logic acc, input logic [2:0] src, input logic ret,
                      input logic wt, input logic wn, input logic wl, input logic [7:0] d,
                      input logic ew, input logic ed, input string tag);
    expItem_t e;
    @(negedge clk);
    intAccept = acc; intSrc = src; intReturn = ret;
    wrTopEn = wt; wrNextEn = wn; wrLastEn = wl; wrData = d;
    enWr = ew; enData = ed;
    if (mEn && acc) begin
      mLast = mNext; mNext = mTop; mTop = pageOf(src);
    end else if (mEn && ret) begin
      mTop = mNext; mNext = mLast;
    end else begin
      if (wt) mTop = d;
      if (wn) mNext = d;
      if (wl) mLast = d;
    end
    if (ew) mEn = ed;
    e.top = mTop; e.nxt = mNext; e.lst = mLast; e.en = mEn; e.tag = tag;
    sbQ.push_back(e);
  endtask

  // monitor: compare one cycle after each driven step, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) compare(sbQ.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nBad++;
    nCmp++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    expItem_t r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    r.top = 8'h00; r.nxt = 8'h00; r.lst = 8'h00; r.en = 1'b1; r.tag = "R1 reset";
    compare(r);
    step(0, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R1 idle");
    step(0, 0, 0, 1, 0, 0, 8'h0F, 0, 0, "R6 write live");
    step(1, 1, 0, 0, 0, 0, 8'h00, 0, 0, "R2 push src1");
    step(1, 3, 0, 0, 0, 0, 8'h00, 0, 0, "R3 nested push");
    step(1, 6, 0, 0, 0, 0, 8'h00, 0, 0, "R3 third push discards");
    step(0, 0, 1, 0, 0, 0, 8'h00, 0, 0, "R4 pop");
    step(0, 0, 0, 1, 0, 0, 8'h55, 0, 0, "R6 write in routine");
    step(0, 0, 1, 0, 0, 0, 8'h00, 0, 0, "R4 second pop");
    step(0, 0, 0, 0, 1, 0, 8'h11, 0, 0, "R6 write next");
    step(0, 0, 0, 0, 0, 1, 8'h22, 0, 0, "R6 write last");
    step(1, 4, 0, 1, 1, 1, 8'h99, 0, 0, "R7 push beats write");
    step(1, 7, 1, 0, 0, 0, 8'h00, 0, 0, "R8 accept beats return");
    step(0, 0, 0, 0, 0, 0, 8'h00, 1, 0, "R9 disable");
    step(1, 2, 0, 0, 0, 0, 8'h00, 0, 0, "R5 push ignored");
    step(0, 0, 1, 0, 0, 0, 8'h00, 0, 0, "R5 pop ignored");
    step(0, 0, 0, 1, 0, 0, 8'h44, 0, 0, "R6 write while disabled");
    step(0, 0, 0, 0, 0, 0, 8'h00, 1, 1, "R9 enable");
    step(0, 0, 1, 0, 1, 0, 8'h77, 0, 0, "R7 pop beats write");
    step(0, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R4 idle after pop");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule